// File: doc/BRIEF.md
# Clocked Serial Slave Receiver

This block receives characters over a two-wire clocked serial link whose bit clock is driven by an external master. The serial clock and data lines are brought into the system clock domain through a short synchronizer. Data is then sampled on each detected rising edge of the serial clock, least significant bit first. Each finished character moves into a two-entry receive queue. A host reads that queue through a small register port.

The host selects slave operation and turns reception on through a control register. It polls a status register, or takes an interrupt, to learn that characters are waiting. Characters may be 8 or 9 bits long. In 9-bit mode the extra bit of the oldest stored character appears in the status register, and the host must read it before it pops the low bits from the data register.

If a character completes while the queue is full, an overrun is recorded and that character is dropped. Reception then stays frozen until the host clears the continuous-receive enable or the port enable. Clearing the port enable returns the whole receiver to its reset state.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset every control bit and status bit reads 0, `irq_o` is low, and the data register (address 2) reads 0.
- R2: Characters are received only while control (address 0) has port enable (bit 0) = 1, synchronous mode (bit 1) = 1, internal-clock select (bit 2) = 0 and continuous receive (bit 3) = 1. In any other configuration, serial clock edges store nothing.
- R3: The single-receive bit (control bit 4) has no effect. With it set and continuous receive clear, nothing is received.
- R4: Data is sampled on the rising edge of `sclk_i`, least significant bit first. In 8-bit mode (control bit 5 = 0) a character is 8 bits long and is read from the data register (address 2).
- R5: In 9-bit mode (control bit 5 = 1) a character is 9 bits long. Its most significant bit is shown in status bit 2 for the oldest stored character, and the data register returns the low 8 bits.
- R6: Status bit 0 (character available) is 1 while the queue holds at least one character. Each read of the data register pops one character, oldest first.
- R7: `irq_o` is high exactly when a character is available and interrupt enable (control bit 6) is 1.
- R8: The queue holds two characters. A character that completes while the queue is full sets the overrun flag (status bit 1) and is discarded. The stored characters stay readable in order.
- R9: While the overrun flag is set, no further characters are stored, even after the host frees a queue slot.
- R10: Clearing continuous receive clears the overrun flag. Reception works again once the bit is set again.
- R11: Clearing port enable clears the overrun flag and empties the queue.
- R12: The data register reads 0 while the queue is empty, and such a read pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial bit clock from the external master |
| sdat_i | input | 1 | Serial data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 pops) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach is overrun lockout with a free queue slot. To get there, the bench completes three characters with no read in between, pops one entry, and then clocks in a whole fourth character. A correct design must leave that character unstored. Draining the queue afterwards then shows only the second original character, followed by an empty data read. The bench then clears continuous receive or port enable and checks that reception resumes, which shows the lockout ends on exactly those two controls.

// File: rtl/sync_slave_rx_pkg.sv
package sync_slave_rx_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   // first field is the most significant bit; port_en sits at bit 0
   typedef struct packed {
      logic irq_en;
      logic nine_bit;
      logic single_rx;
      logic rx_cont;
      logic clk_int;
      logic sync_mode;
      logic port_en;
   } ctrl_t;
endpackage

// File: rtl/sync_slave_rx_sync.sv
module sync_slave_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= d_i;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sync_slave_rx_shift.sv
module sync_slave_rx_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              bit_en_i,
   input  logic              bit_i,
   input  logic              nine_i,
   output logic              done_o,
   output logic [DATA_W:0]   word_o
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] LAST8 = CW'(DATA_W - 1);
   localparam logic [CW-1:0] LAST9 = CW'(DATA_W);

   logic [DATA_W:0] sh_q, sh_nx;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   last;

   assign last = nine_i ? LAST9 : LAST8;

   always_comb begin
      sh_nx = sh_q;
      sh_nx[cnt_q] = bit_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         done_o <= 1'b0;
         word_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
         end else if (bit_en_i) begin
            if (cnt_q == last) begin
               cnt_q  <= '0;
               sh_q   <= '0;
               done_o <= 1'b1;
               word_o <= nine_i ? sh_nx : {1'b0, sh_nx[DATA_W-1:0]};
            end else begin
               sh_q  <= sh_nx;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sync_slave_rx_fifo.sv
module sync_slave_rx_fifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_i,
   input  logic                       push_i,
   input  logic [WIDTH-1:0]           wdata_i,
   input  logic                       pop_i,
   output logic [WIDTH-1:0]           head_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp_q, rp_q;
   logic             do_push, do_pop;

   assign do_pop  = pop_i && (count_o != '0);
   assign do_push = push_i && ((count_o != NW'(DEPTH)) || do_pop);
   assign head_o  = mem[rp_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_o <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr_i) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_o <= '0;
      end else begin
         if (do_push) begin
            mem[wp_q] <= wdata_i;
            wp_q      <= (wp_q == PMAX) ? '0 : wp_q + 1'b1;
         end
         if (do_pop) rp_q <= (rp_q == PMAX) ? '0 : rp_q + 1'b1;
         count_o <= count_o + NW'(do_push) - NW'(do_pop);
      end
   end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
   import sync_slave_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
   localparam int CTL_W = $bits(ctrl_t);

   generate
      if (DATA_W < CTL_W) begin : g_bad_w
         $error("DATA_W must hold the control register");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_d
         $error("FIFO_DEPTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic              ovr_q;
   logic              sclk_s, sdat_s, sclk_prev;
   logic              active, rise, done;
   logic [DATA_W:0]   word, head;
   logic [CNT_W-1:0]  fifo_cnt;
   logic              fifo_full, pop, push, port_en, rx_cont;

   assign port_en = ctrl_q.port_en;
   assign rx_cont = ctrl_q.rx_cont;
   assign active  = ctrl_q.port_en && ctrl_q.sync_mode && !ctrl_q.clk_int && ctrl_q.rx_cont;

   sync_slave_rx_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
   sync_slave_rx_sync #(.STAGES(SYNC_STAGES)) u_sdat_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sdat_i), .q_o(sdat_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end
   assign rise = sclk_s && !sclk_prev;

   sync_slave_rx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .clr_i(!active),
      .bit_en_i(rise && active && !ovr_q),
      .bit_i(sdat_s),
      .nine_i(ctrl_q.nine_bit),
      .done_o(done),
      .word_o(word));

   assign pop       = reg_rd && (reg_addr == ADDR_DATA);
   assign fifo_full = (fifo_cnt == CNT_W'(FIFO_DEPTH));
   assign push      = done && !ovr_q && active;

   sync_slave_rx_fifo #(.WIDTH(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .clr_i(!ctrl_q.port_en),
      .push_i(push),
      .wdata_i(word),
      .pop_i(pop),
      .head_o(head),
      .count_o(fifo_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTL_W-1:0];
         if (!ctrl_q.port_en || !ctrl_q.rx_cont) ovr_q <= 1'b0;
         else if (push && fifo_full && !pop) ovr_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[CTL_W-1:0] = ctrl_q;
         ADDR_STAT: begin
            reg_rdata[0] = (fifo_cnt != '0);
            reg_rdata[1] = ovr_q;
            reg_rdata[2] = (fifo_cnt != '0) && head[DATA_W];
         end
         ADDR_DATA: if (fifo_cnt != '0) reg_rdata = head[DATA_W-1:0];
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_o = (fifo_cnt != '0) && ctrl_q.irq_en;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk #(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 2,
   parameter int CNT_W      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  fifo_cnt,
   input logic              ovr_q,
   input logic              done,
   input logic              active,
   input logic              port_en,
   input logic              rx_cont,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_rdata
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && port_en && rx_cont) |=> ovr_q); // R9
   AST_OVR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> (fifo_cnt <= $past(fifo_cnt))); // R9
   AST_PORT_OFF_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (fifo_cnt == '0 && !ovr_q)); // R11
   AST_RX_OFF_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_cont |=> !ovr_q); // R10
   AST_DONE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(active)); // R2
   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd2 && fifo_cnt == '0) |-> reg_rdata == '0); // R12
endmodule

bind sync_slave_rx sync_slave_rx_chk #(
   .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .ovr_q(ovr_q),
   .done(done), .active(active), .port_en(port_en), .rx_cont(rx_cont),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata));

// File: tb/sync_slave_rx_tb.sv
`timescale 1ns/1ps
module sync_slave_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_i = 1'b0, sdat_i = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_o;
   int         checks = 0, fails = 0;

   localparam logic [7:0] C_ON   = 8'h0B; // port_en | sync_mode | rx_cont
   localparam logic [7:0] C_INT  = 8'h04;
   localparam logic [7:0] C_ONE  = 8'h10;
   localparam logic [7:0] C_NINE = 8'h20;
   localparam logic [7:0] C_IRQ  = 8'h40;

   always #2 clk = ~clk;

   sync_slave_rx u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

   task automatic check(string req, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
      reg_addr = 2'd0;
   endtask

   task automatic send(logic [8:0] v, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sdat_i = v[i];
         repeat (4) @(negedge clk);
         sclk_i = 1'b1;
         repeat (4) @(negedge clk);
         sclk_i = 1'b0;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); check("R1 ctrl", d, 0);
      rd(2'd1, d); check("R1 stat", d, 0);
      check("R1 irq", irq_o, 0);
      rd(2'd2, d); check("R1 data", d, 0);
   endtask

   task automatic t_config_gate();
      logic [7:0] d;
      wr(2'd0, C_ON | C_INT);
      send(9'h5A, 8);
      rd(2'd1, d); check("R2 internal clock select", d, 0);
      wr(2'd0, 8'h09);
      send(9'h5A, 8);
      rd(2'd1, d); check("R2 sync mode off", d, 0);
      wr(2'd0, 8'h03 | C_ONE);
      send(9'h5A, 8);
      rd(2'd1, d); check("R3 single receive ignored", d, 0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      wr(2'd0, C_ON | C_IRQ);
      send(9'hA5, 8);
      rd(2'd1, d); check("R6 available", d, 8'h01);
      check("R7 irq high", irq_o, 1);
      rd(2'd2, d); check("R4 data lsb first", d, 8'hA5);
      rd(2'd1, d); check("R6 empty after pop", d, 0);
      check("R7 irq low", irq_o, 0);
      rd(2'd2, d); check("R12 empty data", d, 0);
      wr(2'd0, C_ON);
      send(9'h3C, 8);
      check("R7 irq disabled", irq_o, 0);
      rd(2'd2, d); check("R4 second char", d, 8'h3C);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_nine();
      logic [7:0] d;
      wr(2'd0, C_ON | C_NINE);
      send(9'h13C, 9);
      send(9'h0C3, 9);
      rd(2'd1, d); check("R5 ninth bit set", d, 8'h05);
      rd(2'd2, d); check("R5 low bits", d, 8'h3C);
      rd(2'd1, d); check("R5 ninth bit clear", d, 8'h01);
      rd(2'd2, d); check("R5 low bits 2", d, 8'hC3);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_overrun();
      logic [7:0] d;
      wr(2'd0, C_ON);
      send(9'h11, 8); send(9'h22, 8); send(9'h33, 8);
      rd(2'd1, d); check("R8 overrun set", d, 8'h03);
      rd(2'd2, d); check("R8 first kept", d, 8'h11);
      send(9'h44, 8);
      rd(2'd2, d); check("R8 second kept", d, 8'h22);
      rd(2'd1, d); check("R9 nothing stored", d, 8'h02);
      rd(2'd2, d); check("R9 empty data", d, 0);
   endtask

   task automatic t_clear_rx();
      logic [7:0] d;
      wr(2'd0, C_ON & ~8'h08);
      rd(2'd1, d); check("R10 overrun cleared", d, 0);
      wr(2'd0, C_ON);
      send(9'h55, 8);
      rd(2'd2, d); check("R10 resumes", d, 8'h55);
   endtask

   task automatic t_clear_port();
      logic [7:0] d;
      send(9'h66, 8); send(9'h77, 8); send(9'h88, 8);
      rd(2'd1, d); check("R11 overrun before", d, 8'h03);
      wr(2'd0, 8'h00);
      rd(2'd1, d); check("R11 cleared", d, 0);
      wr(2'd0, C_ON);
      send(9'h99, 8);
      rd(2'd2, d); check("R11 fifo emptied", d, 8'h99);
      rd(2'd1, d); check("R11 one entry only", d, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_config_gate();
      t_basic();
      t_nine();
      t_overrun();
      t_clear_rx();
      t_clear_port();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule